// File: doc/BRIEF.md
# Cross-Domain Register Write Tracker

This block is the register front end of a timer peripheral whose registers sit in a slower timer clock domain. Each write to a timer register is captured on the bus side and held there. A toggle request carries it across to the timer domain, where it is loaded. A toggle acknowledge returns to the bus side. When the acknowledge arrives, the block sets a sticky completion flag for that register. Software polls that flag and clears it by writing a one to it.

Each tracked register has its own capture register and its own handshake, so writes to different registers can be in flight at the same time. A second write to a register that is still in flight stalls the bus until the first write completes. The timer counters are outside the block. They are represented only by one load strobe and one value per register.

The block has one bus write port and one combinational status read port. The flags are grouped as follows:
- a global status register for the control and comparator registers;
- a counter status register for the two counter halves;
- one status register for each local timer.

Top module: `xdom_wr_tracker`

## Requirements
- R1: A write to the global control register (address 0x00) sets bit 16 of the global status register (address 0x08) once the write has been applied in the timer domain.
- R2: Writes to the comparator low half (0x01), comparator high half (0x02) and comparator increment (0x03) set bits 0, 1 and 2 of the global status register (0x08), in that order.
- R3: Writes to the counter low half (0x04) and counter high half (0x05) set bits 0 and 1 of the counter status register (0x09).
- R4: Local timer n has registers at 0x10+4n (tick count buffer), 0x11+4n (interrupt count buffer) and 0x12+4n (local control). Writes to them set bits 0, 1 and 3 of that timer's status register at 0x13+4n.
- R5: Writing 1 to a bit of a status register clears that flag. Writing 0 to a bit leaves that flag unchanged.
- R6: If a completion and a clearing write reach the same flag in the same bus cycle, the flag ends up set.
- R7: After a write is accepted, its flag is set within 4 timer-clock cycles plus 4 bus-clock cycles.
- R8: Each accepted write to a register produces exactly one single-cycle load strobe for that register in the timer domain. The register's timer-domain value equals the written data before the flag is set.
- R9: While a write to a register is in flight, a further write to the same register holds bw_ready low until the first write completes. A write to a different register is accepted at once.
- R10: The interrupt enable register (0x06) is loaded in the timer domain but sets no flag. A write to an unmapped address (for example 0x07 or 0x0A) loads nothing and changes no flag.
- R11: After reset, all flags are 0, bw_ready is 1, all load strobes are 0 and all timer-domain values are 0.
- R12: The captured data of a register stays unchanged on the bus side for as long as its write is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| b_clk | input | 1 | Bus clock |
| b_rst_n | input | 1 | Bus-domain reset, active low |
| bw_valid | input | 1 | Bus write request |
| bw_addr | input | ADDR_W | Bus write word address |
| bw_data | input | DATA_W | Bus write data |
| bw_ready | output | 1 | Write accepted when high together with bw_valid |
| rd_addr | input | ADDR_W | Status read address |
| rd_data | output | DATA_W | Status register contents, combinational |
| t_clk | input | 1 | Timer clock |
| t_rst_n | input | 1 | Timer-domain reset, active low |
| t_load | output | 7+3*NUM_LOCAL | One load strobe per register, timer domain |
| t_value | output | (7+3*NUM_LOCAL)*DATA_W | Applied value per register, timer domain |

## Verification
The flag update can receive a completion from the acknowledge path and a write-1-to-clear from the bus in the same bus cycle. The bench cannot see the completion pulse directly. It therefore starts a comparator-increment write and then issues a clear of that flag after a delay. The delay is swept one bus cycle at a time, so that one of the delays lands on the completion cycle. On each run the bench watches the flag up to the clear. It expects the flag to end high exactly when the flag had not yet risen before the clear, so the coincident case must leave the flag set.

// File: rtl/xwt_pkg.sv
package xwt_pkg;
   localparam int GLOBAL_SLOTS = 7;
   localparam int LOCAL_REGS   = 3;

   function automatic int slot_count(input int n_local);
      return GLOBAL_SLOTS + LOCAL_REGS * n_local;
   endfunction

   // word address of the register carried by slot s
   function automatic int slot_addr(input int s);
      if (s < GLOBAL_SLOTS) return s;
      return 16 + 4 * ((s - GLOBAL_SLOTS) / LOCAL_REGS) + (s - GLOBAL_SLOTS) % LOCAL_REGS;
   endfunction

   // status register address of slot s, -1 when the slot has no flag
   function automatic int stat_addr(input int s);
      if (s <= 3) return 8;
      if (s <= 5) return 9;
      if (s == 6) return -1;
      return 19 + 4 * ((s - GLOBAL_SLOTS) / LOCAL_REGS);
   endfunction

   // bit of the flag inside its status register (software decodes these)
   function automatic int stat_bit(input int s);
      int k;
      case (s)
         0: return 16;
         1: return 0;
         2: return 1;
         3: return 2;
         4: return 0;
         5: return 1;
         6: return 0;
         default: begin
            k = (s - GLOBAL_SLOTS) % LOCAL_REGS;
            return (k == 2) ? 3 : k;
         end
      endcase
   endfunction

   function automatic bit is_tracked(input int s);
      return stat_addr(s) >= 0;
   endfunction
endpackage

// File: rtl/xwt_sync.sv
module xwt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xwt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];
endmodule

// File: rtl/xwt_slot.sv
module xwt_slot #(
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              b_clk,
   input  logic              b_rst_n,
   input  logic              b_accept,
   input  logic [DATA_W-1:0] b_wdata,
   output logic              b_busy,
   output logic              b_done,
   input  logic              t_clk,
   input  logic              t_rst_n,
   output logic              t_load,
   output logic [DATA_W-1:0] t_value
);
   logic              req_q, ack_s, ack_d;
   logic [DATA_W-1:0] hold_q;
   logic              req_s, req_d, ack_q, t_edge;

   // bus side: capture and toggle the request
   always_ff @(posedge b_clk or negedge b_rst_n) begin
      if (!b_rst_n) begin
         req_q  <= 1'b0;
         hold_q <= '0;
         ack_d  <= 1'b0;
      end else begin
         ack_d <= ack_s;
         if (b_accept) begin
            req_q  <= ~req_q;
            hold_q <= b_wdata;
         end
      end
   end

   xwt_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
      .clk(b_clk), .rst_n(b_rst_n), .d(ack_q), .q(ack_s));

   assign b_busy = req_q ^ ack_s;
   assign b_done = ack_s ^ ack_d;

   // timer side: detect the request edge, apply, toggle the acknowledge
   xwt_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
      .clk(t_clk), .rst_n(t_rst_n), .d(req_q), .q(req_s));

   assign t_edge = req_s ^ req_d;

   always_ff @(posedge t_clk or negedge t_rst_n) begin
      if (!t_rst_n) begin
         req_d   <= 1'b0;
         ack_q   <= 1'b0;
         t_load  <= 1'b0;
         t_value <= '0;
      end else begin
         req_d  <= req_s;
         t_load <= t_edge;
         ack_q  <= ack_q ^ t_edge;
         if (t_edge) t_value <= hold_q;
      end
   end
endmodule

// File: rtl/xwt_status_map.sv
module xwt_status_map #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int NUM_LOCAL = 2,
   localparam int NS       = xwt_pkg::slot_count(NUM_LOCAL)
) (
   input  logic [NS-1:0]     flag_q,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [NS-1:0]     clr,
   output logic [DATA_W-1:0] rd_data
);
   always_comb begin
      clr = '0;
      for (int s = 0; s < NS; s++) begin
         if (xwt_pkg::is_tracked(s) && wr_valid &&
             wr_addr == ADDR_W'(xwt_pkg::stat_addr(s)) &&
             |(wr_data & (DATA_W'(1) << xwt_pkg::stat_bit(s))))
            clr[s] = 1'b1;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int s = 0; s < NS; s++) begin
         if (xwt_pkg::is_tracked(s) && rd_addr == ADDR_W'(xwt_pkg::stat_addr(s)))
            rd_data[xwt_pkg::stat_bit(s)] = flag_q[s];
      end
   end
endmodule

// File: rtl/xdom_wr_tracker.sv
module xdom_wr_tracker #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int NUM_LOCAL   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                               b_clk,
   input  logic                               b_rst_n,
   input  logic                               bw_valid,
   input  logic [ADDR_W-1:0]                  bw_addr,
   input  logic [DATA_W-1:0]                  bw_data,
   output logic                               bw_ready,
   input  logic [ADDR_W-1:0]                  rd_addr,
   output logic [DATA_W-1:0]                  rd_data,
   input  logic                               t_clk,
   input  logic                               t_rst_n,
   output logic [7+3*NUM_LOCAL-1:0]           t_load,
   output logic [(7+3*NUM_LOCAL)*DATA_W-1:0]  t_value
);
   localparam int NS = xwt_pkg::slot_count(NUM_LOCAL);

   function automatic logic [NS-1:0] track_mask();
      logic [NS-1:0] m;
      for (int s = 0; s < NS; s++) m[s] = xwt_pkg::is_tracked(s);
      return m;
   endfunction
   localparam logic [NS-1:0] TRACKED = track_mask();

   if (DATA_W < 17) begin : g_bad_data_w
      $error("xdom_wr_tracker: DATA_W must hold status bit 16");
   end
   if (NUM_LOCAL < 1) begin : g_bad_local
      $error("xdom_wr_tracker: NUM_LOCAL must be at least 1");
   end
   if (ADDR_W > 30 || (19 + 4 * (NUM_LOCAL - 1)) >= (1 << ADDR_W)) begin : g_bad_addr_w
      $error("xdom_wr_tracker: ADDR_W too narrow for the local timers");
   end

   logic [NS-1:0] hit, busy_vec, done_vec, accept, clr_vec;
   logic [NS-1:0] flag_q;

   for (genvar s = 0; s < NS; s++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(xwt_pkg::slot_addr(s));
      assign hit[s]    = bw_valid && (bw_addr == SLOT_A);
      assign accept[s] = hit[s] && !busy_vec[s];

      xwt_slot #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) slot_i (
         .b_clk   (b_clk),
         .b_rst_n (b_rst_n),
         .b_accept(accept[s]),
         .b_wdata (bw_data),
         .b_busy  (busy_vec[s]),
         .b_done  (done_vec[s]),
         .t_clk   (t_clk),
         .t_rst_n (t_rst_n),
         .t_load  (t_load[s]),
         .t_value (t_value[s*DATA_W +: DATA_W]));
   end

   assign bw_ready = ~|(hit & busy_vec);

   xwt_status_map #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_LOCAL(NUM_LOCAL)) map_i (
      .flag_q  (flag_q),
      .wr_valid(bw_valid),
      .wr_addr (bw_addr),
      .wr_data (bw_data),
      .rd_addr (rd_addr),
      .clr     (clr_vec),
      .rd_data (rd_data));

   // sticky flags: a completion outranks a same-cycle clear
   always_ff @(posedge b_clk or negedge b_rst_n) begin
      if (!b_rst_n) flag_q <= '0;
      else          flag_q <= ((flag_q & ~clr_vec) | done_vec) & TRACKED;
   end
endmodule

// File: rtl/xwt_checker.sv
module xwt_checker #(
   parameter int NUM_LOCAL  = 2,
   parameter int BUSY_LIMIT = 64,
   localparam int NS        = xwt_pkg::slot_count(NUM_LOCAL),
   localparam int CW        = $clog2(BUSY_LIMIT) + 1
) (
   input logic          b_clk,
   input logic          b_rst_n,
   input logic [NS-1:0] clr_vec,
   input logic [NS-1:0] done_vec,
   input logic [NS-1:0] busy_vec,
   input logic [NS-1:0] flag_q
);
   for (genvar s = 0; s < NS; s++) begin : g_chk
      logic [CW-1:0] busy_cnt;
      always_ff @(posedge b_clk or negedge b_rst_n) begin
         if (!b_rst_n)                      busy_cnt <= '0;
         else if (!busy_vec[s])             busy_cnt <= '0;
         else if (busy_cnt < CW'(BUSY_LIMIT)) busy_cnt <= busy_cnt + 1'b1;
      end

      assert_busy_bounded_R7: assert property (@(posedge b_clk) disable iff (!b_rst_n)
         busy_cnt < CW'(BUSY_LIMIT));

      if (xwt_pkg::is_tracked(s)) begin : g_flag
         assert_w1c_clear_R5: assert property (@(posedge b_clk) disable iff (!b_rst_n)
            (clr_vec[s] && !done_vec[s]) |=> !flag_q[s]);
         assert_set_wins_R6: assert property (@(posedge b_clk) disable iff (!b_rst_n)
            done_vec[s] |=> flag_q[s]);
      end
   end
endmodule

module xwt_slot_checker #(
   parameter int DATA_W = 32
) (
   input logic              b_clk,
   input logic              b_rst_n,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] hold
);
   assert_hold_stable_R12: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (busy && $past(busy)) |-> $stable(hold));
   assert_done_closes_R8: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      done |-> $past(busy));
endmodule

bind xdom_wr_tracker xwt_checker #(.NUM_LOCAL(NUM_LOCAL)) chk_i (
   .b_clk(b_clk), .b_rst_n(b_rst_n), .clr_vec(clr_vec),
   .done_vec(done_vec), .busy_vec(busy_vec), .flag_q(flag_q));

bind xwt_slot xwt_slot_checker #(.DATA_W(DATA_W)) slot_chk_i (
   .b_clk(b_clk), .b_rst_n(b_rst_n), .busy(b_busy),
   .done(b_done), .hold(hold_q));

// File: tb/xdom_wr_tracker_tb_top.sv
`timescale 1ns/100ps
module xdom_wr_tracker_tb_top;
   localparam int DW = 32;
   localparam int AW = 8;
   localparam int NL = 2;
   localparam int NS = 7 + 3 * NL;
   localparam int LAT_LIMIT = (4 * 10) / 4 + 4; // 4 timer + 4 bus cycles, in bus cycles

   logic b_clk = 0, t_clk = 0, b_rst_n = 0, t_rst_n = 0;
   logic bw_valid = 0;
   logic [AW-1:0] bw_addr = '0, rd_addr = '0;
   logic [DW-1:0] bw_data = '0;
   logic bw_ready;
   logic [DW-1:0] rd_data;
   logic [NS-1:0] t_load;
   logic [NS*DW-1:0] t_value;
   int n_chk = 0, n_err = 0;
   int load_cnt [NS];

   always #2 b_clk = ~b_clk;
   initial begin #3.5; forever #5 t_clk = ~t_clk; end

   xdom_wr_tracker #(.DATA_W(DW), .ADDR_W(AW), .NUM_LOCAL(NL)) dut_i (.*);

   initial for (int i = 0; i < NS; i++) load_cnt[i] = 0;
   always @(posedge t_clk) for (int i = 0; i < NS; i++) if (t_load[i]) load_cnt[i]++;

   function automatic int reg_addr(int s);
      return (s < 7) ? s : 16 + 4 * ((s - 7) / 3) + (s - 7) % 3;
   endfunction
   function automatic int st_reg(int s);
      if (s < 4) return 8;
      if (s < 6) return 9;
      if (s == 6) return -1;
      return 19 + 4 * ((s - 7) / 3);
   endfunction
   function automatic int st_bit(int s);
      if (s == 0) return 16;
      if (s < 4) return s - 1;
      if (s < 6) return s - 4;
      return ((s - 7) % 3 == 2) ? 3 : (s - 7) % 3;
   endfunction
   function automatic string map_tag(int s);
      if (s == 0) return "R1";
      if (s < 4) return "R2";
      if (s < 6) return "R3";
      return "R4";
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      rd_addr = AW'(a);
      #1;
      d = rd_data;
   endtask

   task automatic bwr(input int a, input logic [DW-1:0] d, output int stalls);
      @(negedge b_clk);
      bw_valid = 1; bw_addr = AW'(a); bw_data = d;
      #1;
      stalls = 0;
      while (!bw_ready) begin stalls++; @(negedge b_clk); #1; end
      @(posedge b_clk);
      @(negedge b_clk);
      bw_valid = 0;
   endtask

   task automatic clear_all();
      int st;
      bwr(8, '1, st); bwr(9, '1, st); bwr(19, '1, st); bwr(23, '1, st);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] d, v;
      int st, cyc, lc;
      bit seen;
      repeat (3) @(negedge b_clk);
      b_rst_n = 1; t_rst_n = 1;
      repeat (2) @(negedge b_clk);

      // R11: reset state
      foreach (st_reg_list[i]) begin
         rd(st_reg_list[i], d);
         chk(d == 0, "R11 status", d, 0);
      end
      chk(bw_ready == 1'b1, "R11 ready", DW'(bw_ready), 1);
      chk(t_load == '0, "R11 load", DW'(t_load), 0);
      chk(t_value == '0, "R11 value", t_value[DW-1:0], 0);

      // R1-R5, R7, R8, R10: sweep every register
      for (int s = 0; s < NS; s++) begin
         v = (s + 1) * 32'h0F1E_2D3C ^ 32'h5A00_00A5;
         lc = load_cnt[s];
         bwr(reg_addr(s), v, st);
         if (st_reg(s) >= 0) begin
            cyc = 0;
            rd(st_reg(s), d);
            while (d[st_bit(s)] == 1'b0 && cyc < 40) begin
               @(negedge b_clk); cyc++; rd(st_reg(s), d);
            end
            chk(cyc <= LAT_LIMIT, "R7 latency", DW'(cyc), DW'(LAT_LIMIT));
            chk(d == (DW'(1) << st_bit(s)), map_tag(s), d, DW'(1) << st_bit(s));
            chk(t_value[s*DW +: DW] == v, "R8 value", t_value[s*DW +: DW], v);
            chk(load_cnt[s] - lc == 1, "R8 strobe", DW'(load_cnt[s] - lc), 1);
            bwr(st_reg(s), ~(DW'(1) << st_bit(s)), st);
            rd(st_reg(s), d);
            chk(d[st_bit(s)] == 1'b1, "R5 write0 keeps", DW'(d[st_bit(s)]), 1);
            bwr(st_reg(s), DW'(1) << st_bit(s), st);
            rd(st_reg(s), d);
            chk(d == 0, "R5 write1 clears", d, 0);
         end else begin
            repeat (40) @(negedge b_clk);
            foreach (st_reg_list[i]) begin
               rd(st_reg_list[i], d);
               chk(d == 0, "R10 no flag", d, 0);
            end
            chk(t_value[s*DW +: DW] == v, "R10 applied", t_value[s*DW +: DW], v);
            chk(load_cnt[s] - lc == 1, "R10 strobe", DW'(load_cnt[s] - lc), 1);
         end
      end

      // R10: unmapped addresses
      begin
         int tot0, tot1;
         tot0 = 0; foreach (load_cnt[i]) tot0 += load_cnt[i];
         bwr(7, 32'hFFFF_FFFF, st);
         chk(st == 0, "R10 unmapped ready", DW'(st), 0);
         bwr(10, 32'hFFFF_FFFF, st);
         repeat (40) @(negedge b_clk);
         tot1 = 0; foreach (load_cnt[i]) tot1 += load_cnt[i];
         chk(tot1 == tot0, "R10 unmapped load", DW'(tot1), DW'(tot0));
         foreach (st_reg_list[i]) begin
            rd(st_reg_list[i], d);
            chk(d == 0, "R10 unmapped flag", d, 0);
         end
      end

      // R9: same-register stall, other register accepted at once
      lc = load_cnt[1];
      bwr(1, 32'hAAAA_0001, st);
      @(negedge b_clk);
      bw_valid = 1; bw_addr = 8'h02; bw_data = 32'h0000_BEEF;
      #1;
      chk(bw_ready == 1'b1, "R9 other register", DW'(bw_ready), 1);
      @(negedge b_clk);
      bw_addr = 8'h01; bw_data = 32'hBBBB_0002;
      #1;
      chk(bw_ready == 1'b0, "R9 stall", DW'(bw_ready), 0);
      st = 0;
      while (!bw_ready) begin st++; @(negedge b_clk); #1; end
      @(posedge b_clk);
      @(negedge b_clk);
      bw_valid = 0;
      chk(st > 0, "R9 stall cycles", DW'(st), 1);
      repeat (40) @(negedge b_clk);
      chk(t_value[1*DW +: DW] == 32'hBBBB_0002, "R9 final value", t_value[1*DW +: DW], 32'hBBBB_0002);
      chk(load_cnt[1] - lc == 2, "R9 two loads", DW'(load_cnt[1] - lc), 2);
      clear_all();

      // R6: sweep the clear across the completion cycle (comparator increment, bit 2)
      for (int dly = 0; dly < 18; dly++) begin
         bwr(3, DW'(dly), st);
         seen = 0;
         for (int k = 0; k < dly; k++) begin
            @(negedge b_clk); rd(8, d); seen |= d[2];
         end
         @(negedge b_clk);
         rd(8, d); seen |= d[2];
         bw_valid = 1; bw_addr = 8'h08; bw_data = 32'h4;
         @(posedge b_clk);
         @(negedge b_clk);
         bw_valid = 0;
         repeat (24) @(negedge b_clk);
         rd(8, d);
         chk(d[2] == !seen, "R6 set versus clear", DW'(d[2]), DW'(!seen));
         bwr(8, 32'h4, st);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   int st_reg_list [4] = '{8, 9, 19, 23};
endmodule